// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block collects interrupt requests from eighteen peripheral groups and picks one to hand to the processor. Each group has a control register. It holds a 3-bit priority level, where 0 is the most urgent, and a sticky pending flag. A request pulse sets the pending flag. The flag stays set until software clears it by writing that group's control register. Any number of groups may share a level. When they do, the group with the lower index wins.

A pending group is eligible only when the processor's global enable input is 1 and the group's level is strictly below the processor's current mask level. The winner is loaded into an output register and offered on a valid/ready channel, together with its level, its group index and a 32-bit vector. The upper half of the vector is the constant 0x4000. The lower half comes from one of eight per-level vector registers.

Rules for the valid/ready channel:
- While valid is high and ready is low, the output holds steady. Later and more urgent requests wait; they do not replace the offered one.
- A transfer happens on an edge where valid and ready are both high. The accepted group index is then copied into a group-identification register that software can read.
- After each transfer, valid drops for at least one cycle before the next winner is loaded.

Registers are reached through a write port and a combinational read port that share one address map:
- Group control registers sit at addresses 0 to 17.
- Vector registers for levels 0 to 7 sit at addresses 32 to 39.
- The group-identification register sits at address 48.

Top module: `grp_irq_arbiter`

## Requirements
- R1: After reset, `req_valid` is 0, every group control register reads 0x0007 (level 7, not pending), every vector register reads 0 and the group-identification register reads 31.
- R2: A 1 on `irq_in[g]` for one cycle sets group g's pending flag, which reads as bit 7 of the register at address g. The flag stays set until a write to address g with data bit 7 set clears it. If `irq_in[g]` is high in the cycle of that clearing write, the flag stays set.
- R3: A write to address g (0..17) stores data bits 2:0 as group g's level. A write with bit 7 clear leaves the pending flag unchanged.
- R4: A pending group is offered only while `psw_ie` is 1 and its level is strictly less than `psw_im`.
- R5: Among eligible groups, the lowest level number wins.
- R6: Among eligible groups of equal level, the lowest group index wins.
- R7: `req_vector` is 0x4000 in bits 31:16. Bits 15:0 are the vector register of the offered level, with bit 0 forced to 0. A write to address 32+L stores data into the register for level L with bit 0 cleared.
- R8: While `req_valid` is 1 and `req_ready` is 0, valid, level, group and vector stay unchanged, even if a more urgent request arrives.
- R9: A request sets its pending flag on the next edge, and the group is offered one edge after that. After a transfer, `req_valid` is 0 for one cycle, and then the current winner is offered.
- R10: The register at address 48 reads the group index of the most recent transfer in bits 4:0.
- R11: Writes to addresses that map to no register (18..31, 40..47, 48 and above) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 18 | Per-group request pulses |
| psw_ie | input | 1 | Global interrupt enable |
| psw_im | input | 3 | Current mask level |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Write address |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 6 | Read address |
| cfg_rdata | output | 16 | Read data (combinational) |
| req_valid | output | 1 | Interrupt offered |
| req_ready | input | 1 | Processor takes the offered interrupt |
| req_level | output | 3 | Level of the offered group |
| req_group | output | 5 | Index of the offered group |
| req_vector | output | 32 | Vector address of the offered interrupt |

## Verification
The arbiter is driven with several request patterns, each built to tell one rule apart from its near neighbours:
- Single requests placed on either side of the mask threshold and under both enable values isolate the gating. The threshold cases separate "strictly below" from "below or equal".
- Two simultaneous requests at different levels, one from a high group index at an urgent level and one from a low index at a lax level, separate level priority from index priority.
- Three groups sharing one level check that ties go to the lowest index. After that winner is cleared, the next index must follow.
- An urgent request arriving while a lax one is held separates holding the offer from replacing it.
- A clearing write issued while the request line is high separates the case where set wins from the case where clear wins.

// File: rtl/gia_pkg.sv
package gia_pkg;
  localparam int GIA_GROUPS   = 18;
  localparam int GIA_LVL_W    = 3;
  localparam int GIA_VEC_LO_W = 16;
  localparam int GIA_ADDR_W   = 6;
  localparam int GIA_DATA_W   = 16;
  localparam int GIA_CLR_BIT  = 7;
  localparam int GIA_VEC_BASE = 32;
  localparam int GIA_ID_ADDR  = 48;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_GROUP,
    RK_VEC,
    RK_ID
  } reg_kind_e;

  function automatic int gid_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gia_group_regs.sv
module gia_group_regs #(
  parameter int NG      = 18,
  parameter int LVL_W   = 3,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int CLR_BIT = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NG-1:0]          irq_in,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_hit,
  output logic [NG*LVL_W-1:0]    lvl_flat,
  output logic [NG-1:0]          pend
);
  localparam logic [LVL_W-1:0] LVL_RST = '1;

  logic [NG-1:0] clr_hit;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic hit_w;
    assign hit_w      = wr_en && (wr_addr == ADDR_W'(g));
    assign clr_hit[g] = hit_w && wr_data[CLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_flat[g*LVL_W +: LVL_W] <= LVL_RST;
      end else if (hit_w) begin
        lvl_flat[g*LVL_W +: LVL_W] <= wr_data[LVL_W-1:0];
      end
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[g] && !clr_hit[g]) |=> pend[g]);  // R2
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_hit) | irq_in;
  end

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    for (int g = 0; g < NG; g++) begin
      if (rd_addr == ADDR_W'(g)) begin
        rd_hit                = 1'b1;
        rd_data[LVL_W-1:0]    = lvl_flat[g*LVL_W +: LVL_W];
        rd_data[CLR_BIT]      = pend[g];
      end
    end
  end

  AST_PEND_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(irq_in)) == '0));  // R2
endmodule

// File: rtl/gia_vec_regs.sv
module gia_vec_regs #(
  parameter int LVL_W    = 3,
  parameter int VEC_LO_W = 16,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16,
  parameter int VEC_BASE = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [LVL_W-1:0]    sel_lvl,
  output logic [VEC_LO_W-1:0] sel_vec,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_hit
);
  localparam int NUM_LVL = 2 ** LVL_W;

  logic [VEC_LO_W-1:0] vec_q [NUM_LVL];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_vec
    logic hit_w;
    assign hit_w = wr_en && (wr_addr == ADDR_W'(VEC_BASE + l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vec_q[l] <= '0;
      else if (hit_w) vec_q[l] <= {wr_data[VEC_LO_W-1:1], 1'b0};
    end
  end

  assign sel_vec = vec_q[sel_lvl];

  always_comb begin
    rd_data = '0;
    rd_hit  = 1'b0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (rd_addr == ADDR_W'(VEC_BASE + l)) begin
        rd_hit  = 1'b1;
        rd_data = DATA_W'(vec_q[l]);
      end
    end
  end
endmodule

// File: rtl/gia_pick.sv
module gia_pick #(
  parameter int NG    = 18,
  parameter int LVL_W = 3,
  parameter int GID_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NG-1:0]        pend,
  input  logic [NG*LVL_W-1:0]  lvl_flat,
  input  logic                 ie,
  input  logic [LVL_W-1:0]     im,
  output logic                 any,
  output logic [GID_W-1:0]     win_grp,
  output logic [LVL_W-1:0]     win_lvl
);
  logic [NG-1:0] elig;

  for (genvar g = 0; g < NG; g++) begin : g_elig
    assign elig[g] = pend[g] && ie && (lvl_flat[g*LVL_W +: LVL_W] < im);
  end

  // Scan from the top index down; "<=" lets a lower index take a tie.
  always_comb begin
    any     = 1'b0;
    win_grp = '0;
    win_lvl = '0;
    for (int g = NG - 1; g >= 0; g--) begin
      if (elig[g] && (!any || lvl_flat[g*LVL_W +: LVL_W] <= win_lvl)) begin
        any     = 1'b1;
        win_grp = GID_W'(g);
        win_lvl = lvl_flat[g*LVL_W +: LVL_W];
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_chk
    AST_WIN_LOWEST_LVL: assert property (@(posedge clk) disable iff (!rst_n)
      elig[g] |-> (any && lvl_flat[g*LVL_W +: LVL_W] >= win_lvl));  // R5
    AST_WIN_TIE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (elig[g] && lvl_flat[g*LVL_W +: LVL_W] == win_lvl) |-> (win_grp <= GID_W'(g)));  // R6
  end
endmodule

// File: rtl/grp_irq_arbiter.sv
module grp_irq_arbiter
  import gia_pkg::*;
#(
  parameter int          NG       = GIA_GROUPS,
  parameter int          LVL_W    = GIA_LVL_W,
  parameter int          VEC_LO_W = GIA_VEC_LO_W,
  parameter int          ADDR_W   = GIA_ADDR_W,
  parameter int          DATA_W   = GIA_DATA_W,
  parameter int          CLR_BIT  = GIA_CLR_BIT,
  parameter int          VEC_BASE = GIA_VEC_BASE,
  parameter int          ID_ADDR  = GIA_ID_ADDR,
  parameter logic [15:0] VEC_HI   = 16'h4000,
  localparam int         GID_W    = gid_width(NG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NG-1:0]         irq_in,
  input  logic                  psw_ie,
  input  logic [LVL_W-1:0]      psw_im,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  input  logic [ADDR_W-1:0]     cfg_raddr,
  output logic [DATA_W-1:0]     cfg_rdata,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [LVL_W-1:0]      req_level,
  output logic [GID_W-1:0]      req_group,
  output logic [16+VEC_LO_W-1:0] req_vector
);
  localparam logic [GID_W-1:0] NONE_ID = '1;

  logic [NG*LVL_W-1:0] lvl_flat;
  logic [NG-1:0]       pend;
  logic                any;
  logic [GID_W-1:0]    win_grp;
  logic [LVL_W-1:0]    win_lvl;
  logic [VEC_LO_W-1:0] sel_vec;
  logic [DATA_W-1:0]   grp_rd, vec_rd;
  logic                grp_hit, vec_hit;
  logic [GID_W-1:0]    id_q;
  logic                xfer;
  reg_kind_e           rkind;

  gia_group_regs #(
    .NG(NG), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_BIT(CLR_BIT)
  ) u_grp (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .rd_addr(cfg_raddr), .rd_data(grp_rd), .rd_hit(grp_hit),
    .lvl_flat(lvl_flat), .pend(pend)
  );

  gia_vec_regs #(
    .LVL_W(LVL_W), .VEC_LO_W(VEC_LO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VEC_BASE(VEC_BASE)
  ) u_vec (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .sel_lvl(win_lvl), .sel_vec(sel_vec),
    .rd_addr(cfg_raddr), .rd_data(vec_rd), .rd_hit(vec_hit)
  );

  gia_pick #(
    .NG(NG), .LVL_W(LVL_W), .GID_W(GID_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n), .pend(pend), .lvl_flat(lvl_flat),
    .ie(psw_ie), .im(psw_im),
    .any(any), .win_grp(win_grp), .win_lvl(win_lvl)
  );

  assign xfer = req_valid && req_ready;

  // Output stage: hold while offered, drop for one cycle after a transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_level  <= '0;
      req_group  <= '0;
      req_vector <= '0;
    end else if (req_valid) begin
      if (req_ready) req_valid <= 1'b0;
    end else if (any) begin
      req_valid  <= 1'b1;
      req_level  <= win_lvl;
      req_group  <= win_grp;
      req_vector <= {VEC_HI, sel_vec[VEC_LO_W-1:1], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    id_q <= NONE_ID;
    else if (xfer) id_q <= req_group;
  end

  always_comb begin
    if (grp_hit)                           rkind = RK_GROUP;
    else if (vec_hit)                      rkind = RK_VEC;
    else if (cfg_raddr == ADDR_W'(ID_ADDR)) rkind = RK_ID;
    else                                   rkind = RK_NONE;
  end

  always_comb begin
    unique case (rkind)
      RK_GROUP: cfg_rdata = grp_rd;
      RK_VEC:   cfg_rdata = vec_rd;
      RK_ID:    cfg_rdata = DATA_W'(id_q);
      default:  cfg_rdata = '0;
    endcase
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_level) && $stable(req_group) && $stable(req_vector)));  // R8
  AST_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !req_valid);  // R9
  AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> ($past(psw_ie) && (req_level < $past(psw_im))));  // R4
  AST_ID_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (id_q == $past(req_group)));  // R10
endmodule

// File: tb/grp_irq_arbiter_tb_top.sv
`timescale 1ns/1ps
module grp_irq_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] irq_in;
  logic        psw_ie;
  logic [2:0]  psw_im;
  logic        cfg_we;
  logic [5:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [5:0]  cfg_raddr;
  logic [15:0] cfg_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_level;
  logic [4:0]  req_group;
  logic [31:0] req_vector;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  grp_irq_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .psw_ie(psw_ie), .psw_im(psw_im),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_level(req_level),
    .req_group(req_group), .req_vector(req_vector)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; psw_ie = 1'b0; psw_im = 3'd0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; cfg_raddr = '0; req_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    cfg_raddr = a;
    #1;
    d = cfg_rdata;
  endtask

  // Pulse for one cycle, then wait the cycle in which a winner loads.
  task automatic pulse(input logic [17:0] m);
    irq_in = m;
    @(negedge clk);
    irq_in = '0;
    @(negedge clk);
  endtask

  task automatic accept();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    psw_ie = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    bit ok;
    do_reset();
    chk(req_valid == 1'b0, "R1 valid low", 32'(req_valid), 0);
    rd(6'd48, d); chk(d == 16'd31, "R1 id reg", 32'(d), 31);
    ok = 1;
    for (int g = 0; g < 18; g++) begin rd(6'(g), d); if (d != 16'h0007) ok = 0; end
    chk(ok, "R1 group regs", 32'(ok), 1);
    ok = 1;
    for (int l = 0; l < 8; l++) begin rd(6'(32 + l), d); if (d != 16'h0000) ok = 0; end
    chk(ok, "R1 vector regs", 32'(ok), 1);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    do_reset();
    wr(6'd3, 16'h0002);
    pulse(18'h00008);
    rd(6'd3, d); chk(d == 16'h0082, "R2 pending set", 32'(d), 32'h82);
    wr(6'd3, 16'h0005);
    rd(6'd3, d); chk(d == 16'h0085, "R3 level write keeps pending", 32'(d), 32'h85);
    wr(6'd3, 16'h0085);
    rd(6'd3, d); chk(d == 16'h0005, "R2 clear write", 32'(d), 32'h05);
    irq_in = 18'h00008;
    wr(6'd3, 16'h0080);
    irq_in = '0;
    rd(6'd3, d); chk(d == 16'h0080, "R2 request beats clear", 32'(d), 32'h80);
  endtask

  task automatic t_gate();
    do_reset();
    wr(6'd5, 16'h0003);
    psw_ie = 1'b0; psw_im = 3'd7;
    pulse(18'h00020);
    chk(req_valid == 1'b0, "R4 enable off", 32'(req_valid), 0);
    psw_ie = 1'b1; psw_im = 3'd3;
    @(negedge clk);
    chk(req_valid == 1'b0, "R4 level equal to mask", 32'(req_valid), 0);
    psw_im = 3'd4;
    @(negedge clk);
    chk(req_valid && req_group == 5'd5 && req_level == 3'd3, "R4 level below mask",
        {req_valid, 19'd0, req_group, 4'd0, req_level}, {1'b1, 19'd0, 5'd5, 4'd0, 3'd3});
  endtask

  task automatic t_level();
    do_reset();
    wr(6'd2, 16'h0005);
    wr(6'd10, 16'h0001);
    psw_ie = 1'b1; psw_im = 3'd7;
    pulse(18'h00404);
    chk(req_valid && req_group == 5'd10 && req_level == 3'd1, "R5 lowest level wins",
        {27'(req_group), req_level}, {27'd10, 3'd1});
  endtask

  task automatic t_tie();
    do_reset();
    wr(6'd4, 16'h0002); wr(6'd9, 16'h0002); wr(6'd15, 16'h0002);
    psw_ie = 1'b1; psw_im = 3'd7;
    pulse(18'h08210);
    chk(req_valid && req_group == 5'd4, "R6 lowest index on tie", 32'(req_group), 4);
    accept();
    wr(6'd4, 16'h0082);
    psw_ie = 1'b1;
    @(negedge clk);
    chk(req_valid && req_group == 5'd9, "R6 next index after clear", 32'(req_group), 9);
  endtask

  task automatic t_vector();
    logic [15:0] d;
    do_reset();
    wr(6'd38, 16'h1235);
    rd(6'd38, d); chk(d == 16'h1234, "R7 vector bit0 forced", 32'(d), 32'h1234);
    wr(6'd0, 16'h0006);
    psw_ie = 1'b1; psw_im = 3'd7;
    pulse(18'h00001);
    chk(req_valid && req_vector == 32'h4000_1234, "R7 vector address", req_vector, 32'h4000_1234);
  endtask

  task automatic t_hold();
    do_reset();
    wr(6'd7, 16'h0004);
    psw_ie = 1'b1; psw_im = 3'd7;
    pulse(18'h00080);
    chk(req_valid && req_group == 5'd7, "R9 offered one edge after pending", 32'(req_group), 7);
    wr(6'd1, 16'h0000);
    pulse(18'h00002);
    chk(req_valid && req_group == 5'd7 && req_level == 3'd4, "R8 offer held",
        32'(req_group), 7);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(req_valid == 1'b0, "R9 bubble after transfer", 32'(req_valid), 0);
    @(negedge clk);
    chk(req_valid && req_group == 5'd1 && req_level == 3'd0, "R9 next winner offered",
        32'(req_group), 1);
  endtask

  task automatic t_id();
    logic [15:0] d;
    do_reset();
    wr(6'd12, 16'h0000);
    psw_ie = 1'b1; psw_im = 3'd7;
    pulse(18'h01000);
    rd(6'd48, d); chk(d == 16'd31, "R10 id before transfer", 32'(d), 31);
    accept();
    rd(6'd48, d); chk(d == 16'd12, "R10 id after transfer", 32'(d), 12);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    do_reset();
    wr(6'd18, 16'h0001);
    wr(6'd40, 16'hFFFF);
    wr(6'd48, 16'h0003);
    wr(6'd47, 16'hFFFF);
    rd(6'd17, d); chk(d == 16'h0007, "R11 group 17 untouched", 32'(d), 7);
    rd(6'd0, d);  chk(d == 16'h0007, "R11 group 0 untouched", 32'(d), 7);
    rd(6'd39, d); chk(d == 16'h0000, "R11 vector 7 untouched", 32'(d), 0);
    rd(6'd48, d); chk(d == 16'd31, "R11 id untouched", 32'(d), 31);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_gate();
    t_level();
    t_tie();
    t_vector();
    t_hold();
    t_id();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule